// File: doc/BRIEF.md
# Error/Event Code Queue with Overflow Marker

This block keeps signed 16-bit error and event codes in first-in, first-out order until a reader takes them out. Detectors push a code whenever they see a fault. The error-read command pops the oldest code and sees it on `popCode` in the same cycle as the pop request. A not-empty flag feeds the error-queue summary bit of an instrument status byte, and an occupancy count reports how many codes are held.

When a code arrives and every slot is taken, the newest stored code is replaced by the fixed overflow code -350 (16'hFEA2). This tells the reader that codes were lost. The store then ignores further arrivals until at least one code has been read out. The depth is a parameter and defaults to 8 entries.

Top module: `evtQueue`

## Requirements
- R1: Codes are popped in the same order they were pushed.
- R2: A pop on a non-empty queue removes the head code, so the count drops by one when no push is stored in that cycle.
- R3: A push to a full queue with no pop in that cycle stores nothing new. It replaces the newest stored code with -350 (16'hFEA2), and the count stays at DEPTH.
- R4: Once the newest slot holds the overflow code, further pushes without a pop are discarded. After any pop, the next push is stored again.
- R5: `notEmpty` is 1 exactly when the count is non-zero. It drives bit 2 (the error-queue bit) of the status byte.
- R6: A pop on an empty queue returns code 0 on `popCode` and leaves the count unchanged. A push in the same cycle is still stored.
- R7: A push and a pop in the same cycle on a full queue serve the pop first and store the pushed code normally, with no overflow marking.
- R8: `count` reports the current occupancy, from 0 to DEPTH, and is 0 after reset.
- R9: Codes are 16-bit two's-complement values and come out bit-for-bit unchanged, negative values included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| pushValid | input | 1 | Store `pushCode` at this edge |
| pushCode | input | 16 | Signed code to store |
| popReq | input | 1 | Remove the head code at this edge |
| popCode | output | 16 | Head code, or 0 when empty |
| notEmpty | output | 1 | At least one code is held (status byte bit 2) |
| count | output | $clog2(DEPTH+1) | Current occupancy |

## Verification
The bench first fills the queue and pushes twice more. A design that dropped the arriving code instead of marking, or that overwrote the oldest slot, would show a missing -350 or a wrong order when the queue is drained. A pop followed by two pushes checks that the marking is released and then applied again; a design that kept the lock would lose the first of those two codes. A simultaneous push and pop on a full queue must neither mark nor lose data, and a design that evaluated the push before the pop would put -350 in the stream. Pops on an empty queue, alone and together with a push, must return 0 without disturbing the count. A design that moved a pointer in that case would return a stale code later.

// File: rtl/evtQueuePkg.sv
package evtQueuePkg;
  localparam int CODE_W = 16;
  localparam logic signed [CODE_W-1:0] OVF_CODE = -16'sd350;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // store incoming code at write pointer
    logic wrMark;  // overwrite newest slot with overflow code
    logic rdEn;    // advance read pointer
  } qStrobe_t;
endpackage

// File: rtl/evtQueueCtrl.sv
module evtQueueCtrl
  import evtQueuePkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             popReq,
  output qStrobe_t         st,
  output logic [CNT_W-1:0] count
);
  logic marked;
  logic canPop;
  logic isFull;

  always_comb begin
    canPop    = popReq && (count != '0);
    isFull    = (count == CNT_W'(DEPTH));
    st.rdEn   = canPop;
    st.wrEn   = pushValid && (!isFull || canPop);
    st.wrMark = pushValid && isFull && !canPop && !marked;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      marked <= 1'b0;
    end else begin
      case ({st.wrEn, st.rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (st.rdEn)        marked <= 1'b0;
      else if (st.wrMark) marked <= 1'b1;
    end
  end

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  p_pop_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdEn && !st.wrEn) |=> (count == $past(count) - 1'b1));
  p_mark_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.wrMark |=> (count == CNT_W'(DEPTH)));
  p_lock_r4: assert property (@(posedge clk) disable iff (!rstN)
    (marked && pushValid && !popReq) |=> ($stable(count) && marked));
  p_full_push_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && pushValid && popReq) |-> (st.wrEn && !st.wrMark));
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && popReq && !pushValid) |=> (count == '0));
endmodule

// File: rtl/evtQueueData.sv
module evtQueueData
  import evtQueuePkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  qStrobe_t                 st,
  input  logic signed [CODE_W-1:0] pushCode,
  output logic signed [CODE_W-1:0] headCode
);
  logic signed [CODE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, lastPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    lastPtr  = (wrPtr == '0) ? PTR_W'(DEPTH - 1) : wrPtr - 1'b1;
    headCode = mem[rdPtr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (st.wrEn) begin
        mem[wrPtr] <= pushCode;
        wrPtr      <= nextPtr(wrPtr);
      end else if (st.wrMark) begin
        mem[lastPtr] <= OVF_CODE;
      end
      if (st.rdEn) rdPtr <= nextPtr(rdPtr);
    end
  end

  p_mark_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.wrMark |=> (mem[$past(lastPtr)] == OVF_CODE));
  p_store_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.wrEn |=> (mem[$past(wrPtr)] == $past(pushCode)));
  p_mark_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(st.wrMark && (st.wrEn || st.rdEn)));
endmodule

// File: rtl/evtQueue.sv
module evtQueue
  import evtQueuePkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pushValid,
  input  logic signed [CODE_W-1:0] pushCode,
  input  logic                     popReq,
  output logic signed [CODE_W-1:0] popCode,
  output logic                     notEmpty,
  output logic [CNT_W-1:0]         count
);
  qStrobe_t st;
  logic signed [CODE_W-1:0] headCode;

  evtQueueCtrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReq(popReq),
    .st(st), .count(count)
  );

  evtQueueData #(.DEPTH(DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .st(st), .pushCode(pushCode), .headCode(headCode)
  );

  assign notEmpty = (count != '0);
  assign popCode  = notEmpty ? headCode : '0;

  p_flag_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !popReq) |=> notEmpty);
endmodule

// File: tb/test_evtQueue.sv
module test_evtQueue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam logic signed [15:0] OVF = -16'sd350;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0;
  logic signed [15:0] pushCode = '0;
  logic popReq = 1'b0;
  logic signed [15:0] popCode;
  logic notEmpty;
  logic [3:0] count;

  int compared = 0;
  int mismatched = 0;
  logic signed [15:0] expQ[$];
  bit mk = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  evtQueue #(.DEPTH(DEPTH)) i_evtQueue (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushCode(pushCode),
    .popReq(popReq), .popCode(popCode), .notEmpty(notEmpty), .count(count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, scoreboard updated from the requirements
  task automatic step(input bit doPush, input logic signed [15:0] code,
                      input bit doPop, input string tag);
    logic signed [15:0] exp;
    bit popped;
    @(negedge clk);
    pushValid = doPush; pushCode = code; popReq = doPop;
    #1;
    if (doPop) begin
      exp = (expQ.size() > 0) ? expQ[0] : 16'sd0;
      check(popCode == exp, tag, popCode, exp);
    end
    popped = doPop && (expQ.size() > 0);
    if (popped) begin
      void'(expQ.pop_front());
      mk = 1'b0;
    end
    if (doPush) begin
      if (expQ.size() < DEPTH) expQ.push_back(code);
      else if (!mk) begin
        expQ[expQ.size() - 1] = OVF;
        mk = 1'b1;
      end
    end
    @(posedge clk);
    #1;
    pushValid = 1'b0; popReq = 1'b0;
    check(int'(count) == expQ.size(), "R8 count", int'(count), expQ.size());
    check(notEmpty == (expQ.size() != 0), "R5 notEmpty", notEmpty, expQ.size() != 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(count == 0, "R8 reset count", count, 0);
    check(notEmpty == 0, "R5 reset notEmpty", notEmpty, 0);
    check(popCode == 0, "R6 reset popCode", popCode, 0);
    rstN = 1'b1;

    // R1 R9 R2: order and signed values
    step(1, 16'sd12, 0, "R1");
    step(1, -16'sd7, 0, "R9");
    step(1, 16'sh7FFF, 0, "R9");
    step(0, 0, 1, "R1 R2 pop");
    step(0, 0, 1, "R9 pop negative");
    step(0, 0, 1, "R1 pop");

    // R6: pop on empty, alone and with push
    step(0, 0, 1, "R6 empty pop");
    step(1, -16'sd5, 1, "R6 empty pop with push");
    step(0, 0, 1, "R6 stored after empty pop");

    // R3 R4: overflow marking and lock
    for (int i = 0; i < DEPTH; i++) step(1, 16'(100 + i), 0, "R1 fill");
    step(1, 16'sd555, 0, "R3 overflow");
    step(1, 16'sd777, 0, "R4 discarded");
    step(0, 0, 1, "R1 pop head");
    step(1, 16'sd900, 0, "R4 stored after pop");
    step(1, 16'sd901, 0, "R3 re-mark");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, "R3 R4 drain");
    step(0, 0, 1, "R6 drained");

    // R7: push and pop together on a full queue
    for (int i = 0; i < DEPTH; i++) step(1, 16'(200 + i), 0, "R1 fill");
    step(1, 16'sd300, 1, "R7 pop with push");
    step(1, -16'sd1, 1, "R7 second pop with push");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, "R7 drain");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule